// File: doc/BRIEF.md
# Residue Correction Table Builder

This block fills the correction table of an arithmetic error-correcting code whose codewords are multiples of an integer A. Software or an upstream unit supplies a list of candidate error syndromes that is already ranked from most to least likely. Each candidate is a signed sum of up to four powers of two, one term for each physical row that the error touches. The block reduces every candidate modulo A. It hands out each nonzero residue to the first candidate that reaches it, so the more likely errors own the table slots and the less likely ones that collide with them are dropped.

A run starts with a start pulse that latches A and the mode. Candidates are then taken one at a time over a valid/ready handshake. Each installed syndrome produces one table write: the table address is formed from the residue and a half-select bit, and the syndrome value is written alongside. In dual-half mode, candidates that contain the stuck-cell error and candidates that do not fill two independent halves of the table. The run ends when the list's last candidate has been handled or when no free residue is left. A one-cycle done pulse then reports how many entries were installed and how many candidates were skipped. A must be at least 1.

Top module: `syndrome_table_builder`

## Requirements
- R1: A start pulse while idle latches A and the mode, clears all residue claims and both counters, and starts a run. A start pulse during a run is ignored.
- R2: The candidate's syndrome is the sum over its enabled terms of +2^p, or of -2^p when the term's negate bit is set. Here p is that term's position field. Disabled terms add nothing.
- R3: The residue is the syndrome reduced into 0..A-1 (((s mod A) + A) mod A), so negative syndromes map to A minus their magnitude's residue.
- R4: A candidate whose residue is 0 is never written and counts as skipped.
- R5: Candidates are handled strictly in arrival order. A candidate is installed only if its residue is unclaimed in its half; otherwise it counts as skipped.
- R6: Each installed candidate gives exactly one cycle of tbl_wr_o. The address bits [A_W-1:0] hold the residue, bit A_W holds the half, and tbl_syn_o holds the signed syndrome.
- R7: The run stops after the candidate marked last has been handled.
- R8: The run stops as soon as every nonzero residue of each active half is claimed: A-1 entries in single mode, and A-1 in each half in dual mode. No further candidate is accepted. With A=1 the run ends without accepting any candidate.
- R9: In dual mode the half bit equals the candidate's stuck flag, and the two halves claim residues independently. In single mode the half bit is always 0 and the stuck flag is ignored.
- R10: done_o is a single-cycle pulse at the end of a run. installed_o and skipped_o hold their final values until the next start.
- R11: After reset the block is idle, with busy, ready, write, done and both counts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a run (sampled while idle) |
| a_i | input | A_W | Code multiplier A |
| stuck_mode_i | input | 1 | 1 selects dual-half mode |
| cand_valid_i | input | 1 | Candidate present |
| cand_ready_o | output | 1 | Candidate taken when valid and ready |
| cand_last_i | input | 1 | Candidate is the last in the list |
| cand_stuck_i | input | 1 | Candidate includes the stuck-cell error |
| cand_en_i | input | NUM_TERMS | Term enable per row |
| cand_neg_i | input | NUM_TERMS | Term negate per row |
| cand_pos_i | input | NUM_TERMS*POS_W | Bit position per term, term k at [k*POS_W +: POS_W] |
| tbl_wr_o | output | 1 | Table write strobe |
| tbl_addr_o | output | A_W+1 | {half, residue} |
| tbl_syn_o | output | SUM_W | Signed syndrome to store |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |
| installed_o | output | CNT_W | Entries installed this run |
| skipped_o | output | CNT_W | Candidates skipped this run |

## Verification
Single-bit syndromes of both signs at a code multiplier that corrects them all show that every residue is distinct and that the full-table stop lands exactly on the last slot. A tiny multiplier fed with zero-residue, colliding and negative candidates separates the zero-residue rule, the first-come rule and the negative reduction. It also shows that filling the table cuts the list short. The same list run in dual-half and in single-half mode shows that the stuck flag steers the half only in dual mode. A sweep over many multipliers with pseudo-random four-term candidates of both signs is compared write by write against an arithmetic model, and it also covers A=1 and list-end stops.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEXT,
    ST_ACCEPT,
    ST_REDUCE,
    ST_DONE
  } stb_state_e;
endpackage

// File: rtl/stb_syn_sum.sv
module stb_syn_sum #(
  parameter int NUM_TERMS = 4,
  parameter int POS_W     = 5,
  parameter int SUM_W     = 35
) (
  input  logic [NUM_TERMS-1:0]       en_i,
  input  logic [NUM_TERMS-1:0]       neg_i,
  input  logic [NUM_TERMS*POS_W-1:0] pos_i,
  output logic signed [SUM_W-1:0]    sum_o
);
  logic signed [SUM_W-1:0] term [NUM_TERMS];

  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
    logic signed [SUM_W-1:0] mag;
    assign mag = SUM_W'(1) << pos_i[g*POS_W +: POS_W];
    always_comb begin
      term[g] = '0;
      if (en_i[g]) term[g] = neg_i[g] ? -mag : mag;
    end
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NUM_TERMS; k++) sum_o = sum_o + term[k];
  end
endmodule

// File: rtl/stb_residue.sv
// Bit-serial modulo: one magnitude bit per cycle, MSB first.
module stb_residue #(
  parameter int MAG_W = 34,
  parameter int A_W   = 7,
  localparam int CW   = $clog2(MAG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             neg_i,
  input  logic [A_W-1:0]   a_i,
  output logic             done_o,
  output logic [A_W-1:0]   res_o
);
  logic [MAG_W-1:0] sh_q;
  logic [A_W-1:0]   r_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q, neg_q, done_q;
  logic [A_W:0]     t_c, red_c;

  assign t_c   = {r_q, sh_q[MAG_W-1]};
  assign red_c = (t_c >= {1'b0, a_i}) ? t_c - {1'b0, a_i} : t_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      neg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q  <= mag_i;
        r_q   <= '0;
        cnt_q <= '0;
        run_q <= 1'b1;
        neg_q <= neg_i;
      end else if (run_q) begin
        sh_q  <= sh_q << 1;
        r_q   <= A_W'(red_c);
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(MAG_W - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  // negative syndrome: fold into 0..A-1
  assign res_o  = (neg_q && r_q != '0) ? a_i - r_q : r_q;
endmodule

// File: rtl/stb_occupancy.sv
module stb_occupancy #(
  parameter int A_W = 7,
  localparam int ADDR_W = A_W + 1,
  localparam int SLOTS  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [A_W-1:0]    a_i,
  input  logic              dual_i,
  output logic              occupied_o,
  output logic              full_o
);
  logic [SLOTS-1:0] occ_q;
  logic [A_W-1:0]   cnt_q [2];
  logic [A_W-1:0]   limit_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
    end else if (clr_i) begin
      occ_q <= '0;
    end else if (set_i) begin
      occ_q[idx_i] <= 1'b1;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[h] <= '0;
      end else if (clr_i) begin
        cnt_q[h] <= '0;
      end else if (set_i && idx_i[A_W] == 1'(h)) begin
        cnt_q[h] <= cnt_q[h] + A_W'(1);
      end
    end
  end

  assign limit_c    = a_i - A_W'(1);
  assign occupied_o = occ_q[idx_i];
  assign full_o     = (cnt_q[0] == limit_c) && (!dual_i || cnt_q[1] == limit_c);
endmodule

// File: rtl/syndrome_table_builder.sv
module syndrome_table_builder
  import stb_pkg::*;
#(
  parameter int A_W       = 7,
  parameter int POS_W     = 5,
  parameter int NUM_TERMS = 4,
  parameter int CNT_W     = 16,
  localparam int SUM_W  = (1 << POS_W) + $clog2(NUM_TERMS) + 1,
  localparam int MAG_W  = SUM_W - 1,
  localparam int ADDR_W = A_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [A_W-1:0]             a_i,
  input  logic                       stuck_mode_i,
  input  logic                       cand_valid_i,
  output logic                       cand_ready_o,
  input  logic                       cand_last_i,
  input  logic                       cand_stuck_i,
  input  logic [NUM_TERMS-1:0]       cand_en_i,
  input  logic [NUM_TERMS-1:0]       cand_neg_i,
  input  logic [NUM_TERMS*POS_W-1:0] cand_pos_i,
  output logic                       tbl_wr_o,
  output logic [ADDR_W-1:0]          tbl_addr_o,
  output logic signed [SUM_W-1:0]    tbl_syn_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [CNT_W-1:0]           installed_o,
  output logic [CNT_W-1:0]           skipped_o
);
  stb_state_e st_q;
  logic [A_W-1:0]          a_q;
  logic                    dual_q, half_q, last_q;
  logic signed [SUM_W-1:0] sum_q, sum_c;
  logic [MAG_W-1:0]        mag_c;
  logic [CNT_W-1:0]        inst_q, skip_q;
  logic                    wr_q;
  logic [ADDR_W-1:0]       addr_q;

  logic                    clr_c, res_start_c, res_done, take_c, set_c;
  logic                    occupied, full;
  logic [A_W-1:0]          res;

  stb_syn_sum #(.NUM_TERMS(NUM_TERMS), .POS_W(POS_W), .SUM_W(SUM_W)) u_sum (
    .en_i (cand_en_i),
    .neg_i(cand_neg_i),
    .pos_i(cand_pos_i),
    .sum_o(sum_c)
  );

  assign mag_c = sum_c[SUM_W-1] ? MAG_W'(-sum_c) : MAG_W'(sum_c);

  stb_residue #(.MAG_W(MAG_W), .A_W(A_W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(res_start_c),
    .mag_i  (mag_c),
    .neg_i  (sum_c[SUM_W-1]),
    .a_i    (a_q),
    .done_o (res_done),
    .res_o  (res)
  );

  stb_occupancy #(.A_W(A_W)) u_occ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_c),
    .set_i     (set_c),
    .idx_i     ({half_q, res}),
    .a_i       (a_q),
    .dual_i    (dual_q),
    .occupied_o(occupied),
    .full_o    (full)
  );

  assign clr_c       = (st_q == ST_IDLE) && start_i;
  assign res_start_c = (st_q == ST_ACCEPT) && cand_valid_i;
  assign take_c      = (res != '0) && !occupied;
  assign set_c       = (st_q == ST_REDUCE) && res_done && take_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      dual_q <= 1'b0;
      half_q <= 1'b0;
      last_q <= 1'b0;
      sum_q  <= '0;
      inst_q <= '0;
      skip_q <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          a_q    <= a_i;
          dual_q <= stuck_mode_i;
          last_q <= 1'b0;
          inst_q <= '0;
          skip_q <= '0;
          st_q   <= ST_NEXT;
        end
        ST_NEXT: st_q <= (full || last_q) ? ST_DONE : ST_ACCEPT;
        ST_ACCEPT: if (cand_valid_i) begin
          sum_q  <= sum_c;
          half_q <= dual_q & cand_stuck_i;
          last_q <= cand_last_i;
          st_q   <= ST_REDUCE;
        end
        ST_REDUCE: if (res_done) begin
          if (take_c) begin
            wr_q   <= 1'b1;
            addr_q <= {half_q, res};
            inst_q <= inst_q + CNT_W'(1);
          end else begin
            skip_q <= skip_q + CNT_W'(1);
          end
          st_q <= ST_NEXT;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cand_ready_o = (st_q == ST_ACCEPT);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign tbl_wr_o     = wr_q;
  assign tbl_addr_o   = addr_q;
  assign tbl_syn_o    = sum_q;
  assign installed_o  = inst_q;
  assign skipped_o    = skip_q;
endmodule

module syndrome_table_builder_chk #(
  parameter int A_W   = 7,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             cand_ready_o,
  input logic             tbl_wr_o,
  input logic [A_W:0]     tbl_addr_o,
  input logic [CNT_W-1:0] installed_o,
  input logic [CNT_W-1:0] skipped_o,
  input logic [A_W-1:0]   a_q,
  input logic             dual_q
);
  a_r4_no_zero_residue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> tbl_addr_o[A_W-1:0] != '0);

  a_r3_residue_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> tbl_addr_o[A_W-1:0] < a_q);

  a_r9_single_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_wr_o && !dual_q) |-> !tbl_addr_o[A_W]);

  a_r6_write_counted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> installed_o == $past(installed_o) + CNT_W'(1));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_counts_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(installed_o) && $stable(skipped_o)));

  a_r8_ready_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_ready_o |-> (busy_o && !done_o));

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tbl_wr_o, cand_ready_o, done_o}));
endmodule

bind syndrome_table_builder syndrome_table_builder_chk #(.A_W(A_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cand_ready_o(cand_ready_o),
  .tbl_wr_o    (tbl_wr_o),
  .tbl_addr_o  (tbl_addr_o),
  .installed_o (installed_o),
  .skipped_o   (skipped_o),
  .a_q         (a_q),
  .dual_q      (dual_q)
);

// File: tb/syndrome_table_builder_test.sv
`timescale 1ns/1ps
module syndrome_table_builder_test;
  localparam int A_W = 7, POS_W = 5, NT = 4, CNT_W = 16;
  localparam int SUM_W = (1 << POS_W) + 2 + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, stuck_mode_i = 1'b0;
  logic [A_W-1:0] a_i = '0;
  logic cand_valid_i = 1'b0, cand_last_i = 1'b0, cand_stuck_i = 1'b0;
  logic [NT-1:0] cand_en_i = '0, cand_neg_i = '0;
  logic [NT*POS_W-1:0] cand_pos_i = '0;
  logic cand_ready_o, tbl_wr_o, busy_o, done_o;
  logic [A_W:0] tbl_addr_o;
  logic signed [SUM_W-1:0] tbl_syn_o;
  logic [CNT_W-1:0] installed_o, skipped_o;

  always #2.5 clk = ~clk;

  syndrome_table_builder #(.A_W(A_W), .POS_W(POS_W), .NUM_TERMS(NT), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .a_i(a_i),
    .stuck_mode_i(stuck_mode_i), .cand_valid_i(cand_valid_i),
    .cand_ready_o(cand_ready_o), .cand_last_i(cand_last_i),
    .cand_stuck_i(cand_stuck_i), .cand_en_i(cand_en_i), .cand_neg_i(cand_neg_i),
    .cand_pos_i(cand_pos_i), .tbl_wr_o(tbl_wr_o), .tbl_addr_o(tbl_addr_o),
    .tbl_syn_o(tbl_syn_o), .busy_o(busy_o), .done_o(done_o),
    .installed_o(installed_o), .skipped_o(skipped_o)
  );

  int n_total = 0, n_fail = 0;

  // candidate list
  logic [NT-1:0] c_en [64];
  logic [NT-1:0] c_neg [64];
  logic [POS_W-1:0] c_pos [64][NT];
  bit c_stuck [64];
  int n_cand;

  int exp_addr [256];
  longint exp_syn [256];
  int got_addr [256];
  longint got_syn [256];
  int exp_n, exp_skip, exp_cons, got_n;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic add(input logic [3:0] en, input logic [3:0] neg, input int p0, input int p1,
                     input int p2, input int p3, input bit stuck);
    c_en[n_cand] = en;
    c_neg[n_cand] = neg;
    c_pos[n_cand][0] = POS_W'(p0);
    c_pos[n_cand][1] = POS_W'(p1);
    c_pos[n_cand][2] = POS_W'(p2);
    c_pos[n_cand][3] = POS_W'(p3);
    c_stuck[n_cand] = stuck;
    n_cand++;
  endtask

  task automatic load(input int idx);
    if (idx < n_cand) begin
      cand_valid_i = 1'b1;
      cand_en_i = c_en[idx];
      cand_neg_i = c_neg[idx];
      for (int t = 0; t < NT; t++) cand_pos_i[t*POS_W +: POS_W] = c_pos[idx][t];
      cand_stuck_i = c_stuck[idx];
      cand_last_i = (idx == n_cand - 1);
    end else begin
      cand_valid_i = 1'b0;
      cand_last_i = 1'b0;
    end
  endtask

  // R2 R3 R4 R5 R8 R9 arithmetic model
  task automatic model(input int a, input bit dual);
    bit occ [2][128];
    int cnt [2];
    longint s;
    int r, h;
    for (int i = 0; i < 128; i++) begin occ[0][i] = 0; occ[1][i] = 0; end
    cnt[0] = 0; cnt[1] = 0;
    exp_n = 0; exp_skip = 0; exp_cons = 0;
    for (int i = 0; i < n_cand; i++) begin
      if (cnt[0] == a - 1 && (!dual || cnt[1] == a - 1)) break;
      s = 0;
      for (int t = 0; t < NT; t++)
        if (c_en[i][t]) s += c_neg[i][t] ? -(longint'(1) << c_pos[i][t]) : (longint'(1) << c_pos[i][t]);
      r = int'(s % longint'(a));
      if (r < 0) r += a;
      h = (dual && c_stuck[i]) ? 1 : 0;
      if (r != 0 && !occ[h][r]) begin
        occ[h][r] = 1;
        exp_addr[exp_n] = h * 128 + r;
        exp_syn[exp_n] = s;
        exp_n++;
        cnt[h]++;
      end else exp_skip++;
      exp_cons++;
    end
  endtask

  task automatic run_case(input string lbl, input int a, input bit dual);
    int idx, guard;
    bit pend, fin;
    longint g_inst, g_skip;
    model(a, dual);
    got_n = 0; idx = 0; guard = 0; pend = 0; fin = 0; g_inst = 0; g_skip = 0;
    @(negedge clk);
    start_i = 1'b1; a_i = A_W'(a); stuck_mode_i = dual;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {lbl, " R1 busy after start"}, busy_o, 1);
    load(0);
    while (!fin && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (tbl_wr_o && got_n < 256) begin
        got_addr[got_n] = int'(tbl_addr_o);
        got_syn[got_n] = longint'(tbl_syn_o);
        got_n++;
      end
      if (done_o) begin
        fin = 1;
        g_inst = longint'(installed_o);
        g_skip = longint'(skipped_o);
      end
      if (pend) begin idx++; pend = 0; load(idx); end
      if (cand_ready_o && cand_valid_i) pend = 1;
    end
    load(n_cand);
    chk(fin, {lbl, " R10 done seen (watchdog)"}, fin, 1);
    chk(got_n == exp_n, {lbl, " R5 write count"}, got_n, exp_n);
    for (int k = 0; k < got_n && k < exp_n; k++) begin
      chk(got_addr[k] == exp_addr[k], {lbl, " R6 write address"}, got_addr[k], exp_addr[k]);
      chk(got_syn[k] == exp_syn[k], {lbl, " R2 written syndrome"}, got_syn[k], exp_syn[k]);
    end
    chk(g_inst == longint'(exp_n), {lbl, " R10 installed count"}, g_inst, exp_n);
    chk(g_skip == longint'(exp_skip), {lbl, " R4 R5 skipped count"}, g_skip, exp_skip);
    chk(idx == exp_cons, {lbl, " R7 R8 candidates consumed"}, idx, exp_cons);
    repeat (3) @(negedge clk);
    chk(!cand_ready_o && !busy_o, {lbl, " R8 no accept after stop"}, cand_ready_o, 0);
    chk(longint'(installed_o) == g_inst, {lbl, " R10 installed held"}, installed_o, g_inst);
  endtask

  initial begin
    #(5.0 * 190000);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int unsigned seed;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy_o && !done_o && !cand_ready_o && !tbl_wr_o, "R11 idle outputs in reset", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(installed_o == 0 && skipped_o == 0, "R11 counts after reset", installed_o, 0);
    chk(!busy_o, "R11 busy after reset", busy_o, 0);

    // R2 R8: all single-bit errors for 9-bit words at A=19, then extras
    n_cand = 0;
    for (int i = 0; i < 9; i++) begin
      add(4'b0001, 4'b0000, i, 0, 0, 0, 0);
      add(4'b0001, 4'b0001, i, 0, 0, 0, 0);
    end
    add(4'b0001, 4'b0000, 9, 0, 0, 0, 0);
    add(4'b0001, 4'b0001, 10, 0, 0, 0, 0);
    run_case("A19 single-bit", 19, 0);
    chk(exp_n == 18, "R8 A19 fills 18 slots", exp_n, 18);

    // R3 R4 R5 R8: zero residue, negative, collision, early full at A=3
    n_cand = 0;
    add(4'b0011, 4'b0000, 0, 1, 0, 0, 0);
    add(4'b0001, 4'b0001, 0, 0, 0, 0, 0);
    add(4'b0001, 4'b0000, 1, 0, 0, 0, 0);
    add(4'b0001, 4'b0000, 2, 0, 0, 0, 0);
    add(4'b0001, 4'b0001, 1, 0, 0, 0, 0);
    run_case("A3 corner", 3, 0);
    chk(exp_cons == 4 && exp_skip == 2, "R4 R5 A3 model sanity", exp_cons, 4);

    // R9: dual-half then single-half on the same list
    n_cand = 0;
    add(4'b0001, 4'b0000, 0, 0, 0, 0, 0);
    add(4'b0001, 4'b0000, 0, 0, 0, 0, 1);
    add(4'b0011, 4'b0010, 2, 1, 0, 0, 0);
    add(4'b0001, 4'b0001, 0, 0, 0, 0, 1);
    add(4'b0111, 4'b0101, 3, 0, 4, 0, 1);
    add(4'b1111, 4'b1010, 1, 2, 3, 5, 0);
    add(4'b0001, 4'b0000, 1, 0, 0, 0, 1);
    add(4'b0001, 4'b0001, 3, 0, 0, 0, 0);
    run_case("R9 dual", 5, 1);
    run_case("R9 single", 5, 0);

    // R8: A=1 has no free residue
    n_cand = 0;
    add(4'b0001, 4'b0000, 0, 0, 0, 0, 0);
    add(4'b0001, 4'b0000, 1, 0, 0, 0, 0);
    run_case("R8 A1", 1, 0);

    // R7: short list ends before table is full, large shifts
    n_cand = 0;
    add(4'b1111, 4'b0101, 31, 30, 7, 0, 0);
    add(4'b0011, 4'b0011, 31, 31, 0, 0, 0);
    add(4'b1001, 4'b0000, 20, 0, 0, 12, 0);
    add(4'b0000, 4'b0000, 0, 0, 0, 0, 0);
    add(4'b0001, 4'b0001, 25, 0, 0, 0, 0);
    run_case("R7 A79 short", 79, 0);

    // R1 R3 R5 R9 sweep with pseudo-random multi-row candidates
    seed = 32'h1234_5678;
    for (int a = 2; a <= 13; a++) begin
      for (int d = 0; d < 2; d++) begin
        n_cand = 0;
        for (int i = 0; i < 40; i++) begin
          int w [6];
          for (int k = 0; k < 6; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            w[k] = int'(seed >> 16);
          end
          add(4'(w[0]), 4'(w[1]), w[2] & 31, w[3] & 31, w[4] & 31, w[5] & 31, w[0][4]);
        end
        run_case($sformatf("sweep A%0d d%0d", a, d), a, d[0]);
      end
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule